// File: doc/BRIEF.md
# Dual-Clock Serial Frame Bridge

This block carries fixed-length serial frames from a slow converter clock domain into a faster serial clock domain, with no FIFO. Each domain holds exactly one frame. The receive side collects a frame bit by bit. When the frame is whole, it publishes the frame and raises a ready flag. The transmit side sees the synchronized ready flag, copies the published frame in a single cycle, raises an acknowledge flag, and shifts the frame out. The ready flag drops once the acknowledge has been seen. The acknowledge drops once the last bit has left and the ready flag has gone low. Only then can the receive side publish again.

The upstream converter frames its bit stream with a sync strobe that sits on the first bit of each frame. Downstream logic receives a serial bit, a bit-valid strobe and a frame-sync pulse. A frame that completes before the previous handshake has closed is discarded, and a sticky overrun flag records the loss.

Top module: `ser_frame_bridge`

## Requirements
- R1: While reset is asserted and right after it is released, `tx_sdo`, `tx_fsync`, `tx_bit_vld` and `rx_overrun` are all 0.
- R2: A frame is FRAME_W (default 64) consecutive `rx_bit` samples, and the first of them is the one sampled with `rx_sync` high. The frame leaves on `tx_sdo` in the same bit order it arrived, so the first received bit is the most significant and is sent first.
- R3: Without a completed frame, the transmit side stays idle: `tx_bit_vld`, `tx_fsync` and `tx_sdo` remain 0.
- R4: Each transmitted frame holds `tx_bit_vld` high for exactly FRAME_W consecutive `tx_clk` cycles. `tx_fsync` is a one-cycle pulse that coincides with the first of those bits.
- R5: The published frame does not change while the ready flag is up, so the transmit copy is always one complete frame.
- R6: A frame that completes while the previous handshake is still open is dropped. The frame being sent comes out intact, and `rx_overrun` rises and stays 1 until reset.
- R7: If `rx_sync` is high in the middle of a frame, collection restarts at that bit and the partial frame is discarded.
- R8: `rx_bit` samples taken while no frame is being collected (no `rx_sync` seen since the last frame ended) are ignored.
- R9: If each frame completes after the previous handshake has closed, frames arrive in order with none lost. This includes back-to-back frames at the nominal clock ratio (receive clock roughly one third of the transmit clock).
- R10: Correct transfer holds over a range of receive/transmit clock ratios and unrelated phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Converter serial bit clock |
| rx_rst | input | 1 | Active-high reset, synchronous to rx_clk |
| rx_sync | input | 1 | High on the first bit of a frame |
| rx_bit | input | 1 | Serial data from the converter |
| tx_clk | input | 1 | Downstream serial bit clock |
| tx_rst | input | 1 | Active-high reset, synchronous to tx_clk |
| tx_sdo | output | 1 | Serial data out, most significant bit first |
| tx_fsync | output | 1 | One-cycle pulse on the first output bit |
| tx_bit_vld | output | 1 | High while tx_sdo carries a frame bit |
| rx_overrun | output | 1 | Sticky: a completed frame was dropped (rx_clk domain) |

## Verification
The hardest situation to reach is the overrun. At the nominal clock ratio, the handshake always closes well inside one frame time, so a drop cannot happen. To get there, the bench raises the receive clock above the transmit clock during the run. Two frames are then sent back to back, so the second completes while the first is still shifting out. The bench then checks that only the first frame appears, that the sticky flag stays up through a later clean frame, and that only reset clears it. A sweep over several receive clock periods, each with its own phase relation, exercises the synchronizers with the flags arriving at many offsets.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_HOLD  = 2'd2
  } tx_state_t;

  // true when a zero-based position is the last slot of a run of 'len'
  function automatic logic at_last(input int unsigned pos, input int unsigned len);
    return pos == (len - 1);
  endfunction

endpackage

// File: rtl/sfb_sync.sv
module sfb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sfb_rx_side.sv
module sfb_rx_side
  import sfb_pkg::*;
#(
  parameter int FRAME_W = 64,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_i,
  input  logic               bit_i,
  input  logic               ack_s_i,
  output logic               rdy_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               overrun_o
);
  logic [FRAME_W-1:0] stage_q;
  logic [FRAME_W-1:0] stage_nxt;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               rdy_q;
  logic               ovr_q;

  // named events for the assertions
  logic collecting_w;
  logic frame_done_w;
  logic can_publish_w;
  logic publish_w;
  logic drop_w;

  assign stage_nxt     = {stage_q[FRAME_W-2:0], bit_i};
  assign collecting_w  = (cnt_q != '0);
  assign frame_done_w  = !sync_i && collecting_w && at_last(int'(cnt_q), FRAME_W);
  assign can_publish_w = !rdy_q && !ack_s_i;
  assign publish_w     = frame_done_w && can_publish_w;
  assign drop_w        = frame_done_w && !can_publish_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else if (sync_i) begin
      stage_q <= stage_nxt;
      cnt_q   <= CNT_W'(1);
    end else if (collecting_w) begin
      stage_q <= stage_nxt;
      cnt_q   <= frame_done_w ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      rdy_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (publish_w) begin
        frame_q <= stage_nxt;
        rdy_q   <= 1'b1;
      end else if (ack_s_i) begin
        rdy_q   <= 1'b0;
      end
      if (drop_w) ovr_q <= 1'b1;
    end
  end

  assign rdy_o     = rdy_q;
  assign frame_o   = frame_q;
  assign overrun_o = ovr_q;

  // R5: published frame is frozen while offered
  a_r5_frame_held: assert property (@(posedge clk) disable iff (rst)
    rdy_q |=> $stable(frame_q));
  // R3: ready only rises because a frame completed
  a_r3_ready_from_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(frame_done_w));
  // R6: overrun is sticky
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    ovr_q |=> ovr_q);
  // R6: a dropped frame leaves the published one untouched
  a_r6_drop_keeps_frame: assert property (@(posedge clk) disable iff (rst)
    drop_w |=> ($stable(frame_q) && ovr_q));
  // R7: a sync strobe always restarts collection
  a_r7_sync_restarts: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/sfb_tx_side.sv
module sfb_tx_side
  import sfb_pkg::*;
#(
  parameter int FRAME_W = 64,
  localparam int IDX_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rdy_s_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ack_o,
  output logic               sdo_o,
  output logic               fsync_o,
  output logic               bit_vld_o
);
  tx_state_t          st_q;
  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;
  logic               ack_q;

  // named events for the assertions
  logic shifting_w;
  logic take_w;
  logic last_bit_w;
  logic release_w;

  assign shifting_w = (st_q == TX_SHIFT);
  assign take_w     = (st_q == TX_IDLE) && rdy_s_i;
  assign last_bit_w = shifting_w && at_last(int'(idx_q), FRAME_W);
  assign release_w  = (last_bit_w && !rdy_s_i) || ((st_q == TX_HOLD) && !rdy_s_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= TX_IDLE;
      sh_q  <= '0;
      idx_q <= '0;
      ack_q <= 1'b0;
    end else begin
      unique case (st_q)
        TX_IDLE: begin
          if (take_w) begin
            sh_q  <= frame_i;
            idx_q <= '0;
            ack_q <= 1'b1;
            st_q  <= TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
          idx_q <= idx_q + IDX_W'(1);
          if (last_bit_w) st_q <= rdy_s_i ? TX_HOLD : TX_IDLE;
        end
        TX_HOLD: begin
          if (!rdy_s_i) st_q <= TX_IDLE;
        end
        default: st_q <= TX_IDLE;
      endcase
      if (release_w) ack_q <= 1'b0;
    end
  end

  assign ack_o     = ack_q;
  assign bit_vld_o = shifting_w;
  assign sdo_o     = shifting_w & sh_q[FRAME_W-1];
  assign fsync_o   = shifting_w && (idx_q == '0);

  // R4: frame sync only on a valid bit while the frame is owned
  a_r4_fsync_on_bit: assert property (@(posedge clk) disable iff (rst)
    fsync_o |-> (bit_vld_o && ack_q));
  // R4: a started word runs without gaps until its last bit
  a_r4_no_gap: assert property (@(posedge clk) disable iff (rst)
    (shifting_w && !last_bit_w) |=> shifting_w);
  // R5: acknowledge rises only in answer to a visible ready flag
  a_r5_take_needs_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past(rdy_s_i));
  // R9: acknowledge falls only once ready is seen low
  a_r9_ack_release: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_q) |-> $past(!rdy_s_i));
  // R3: no output bits without an owned frame
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !ack_q |-> (!bit_vld_o && !sdo_o));
endmodule

// File: rtl/ser_frame_bridge.sv
module ser_frame_bridge #(
  parameter int FRAME_W     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic rx_clk,
  input  logic rx_rst,
  input  logic rx_sync,
  input  logic rx_bit,
  input  logic tx_clk,
  input  logic tx_rst,
  output logic tx_sdo,
  output logic tx_fsync,
  output logic tx_bit_vld,
  output logic rx_overrun
);
  logic               rdy_raw;
  logic               rdy_in_tx;
  logic               ack_raw;
  logic               ack_in_rx;
  logic [FRAME_W-1:0] frame_x;

  sfb_rx_side #(.FRAME_W(FRAME_W)) u_rx (
    .clk      (rx_clk),
    .rst      (rx_rst),
    .sync_i   (rx_sync),
    .bit_i    (rx_bit),
    .ack_s_i  (ack_in_rx),
    .rdy_o    (rdy_raw),
    .frame_o  (frame_x),
    .overrun_o(rx_overrun)
  );

  sfb_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(tx_clk), .rst(tx_rst), .d(rdy_raw), .q(rdy_in_tx)
  );

  sfb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(rx_clk), .rst(rx_rst), .d(ack_raw), .q(ack_in_rx)
  );

  sfb_tx_side #(.FRAME_W(FRAME_W)) u_tx (
    .clk      (tx_clk),
    .rst      (tx_rst),
    .rdy_s_i  (rdy_in_tx),
    .frame_i  (frame_x),
    .ack_o    (ack_raw),
    .sdo_o    (tx_sdo),
    .fsync_o  (tx_fsync),
    .bit_vld_o(tx_bit_vld)
  );

  // R1: overrun cannot be set straight out of reset
  a_r1_overrun_reset: assert property (@(posedge rx_clk)
    $past(rx_rst) |-> !rx_overrun);
endmodule

// File: tb/ser_frame_bridge_tb.sv
`timescale 1ns/1ps
module ser_frame_bridge_tb;
  localparam int W = 64;

  logic tx_clk = 1'b0;
  logic rx_clk = 1'b0;
  logic rst = 1'b1;
  logic rx_sync = 1'b0;
  logic rx_bit = 1'b0;
  logic tx_sdo, tx_fsync, tx_bit_vld, rx_overrun;
  real  rx_half = 8.138;

  int total = 0;
  int bad = 0;

  logic [W-1:0] exp_q[$];
  logic [W-1:0] got_q[$];
  logic [W-1:0] mon_acc = '0;
  int           mon_cnt = 0;
  int           mon_err = 0;

  ser_frame_bridge #(.FRAME_W(W)) u_dut (
    .rx_clk(rx_clk), .rx_rst(rst), .rx_sync(rx_sync), .rx_bit(rx_bit),
    .tx_clk(tx_clk), .tx_rst(rst), .tx_sdo(tx_sdo), .tx_fsync(tx_fsync),
    .tx_bit_vld(tx_bit_vld), .rx_overrun(rx_overrun)
  );

  always #2.5 tx_clk = ~tx_clk;
  always #(rx_half) rx_clk = ~rx_clk;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // output monitor, samples away from the tx edge
  always @(negedge tx_clk) begin
    if (rst) begin
      mon_cnt = 0;
    end else begin
      if (tx_fsync && !tx_bit_vld) mon_err++;
      if (tx_bit_vld) begin
        if (tx_fsync != (mon_cnt == 0)) mon_err++;
        mon_acc = {mon_acc[W-2:0], tx_sdo};
        mon_cnt++;
        if (mon_cnt == W) begin
          got_q.push_back(mon_acc);
          mon_cnt = 0;
        end
      end else begin
        if (mon_cnt != 0) mon_err++;
        if (tx_sdo) mon_err++;
      end
    end
  end

  function automatic logic [W-1:0] pat(input int k);
    logic [31:0] hi, lo;
    hi = (32'(k) * 32'h9E3779B9) ^ 32'hC3A55A3C;
    lo = (32'(k + 7) * 32'h85EBCA6B) + 32'h1234;
    return {hi, lo};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    rx_sync = 1'b0;
    rx_bit = 1'b0;
    repeat (4) @(negedge rx_clk);
    repeat (4) @(negedge tx_clk);
    @(negedge rx_clk);
    rst = 1'b0;
  endtask

  task automatic send_bits(input logic [W-1:0] f, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge rx_clk);
      rx_sync = (i == 0);
      rx_bit  = f[W-1-i];
    end
  endtask

  task automatic idle_rx(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rx_clk);
      rx_sync = 1'b0;
      rx_bit  = 1'b0;
    end
  endtask

  task automatic drain();
    repeat (600) @(negedge tx_clk);
  endtask

  task automatic compare(input string req);
    chk(got_q.size() == exp_q.size(), req, W'(got_q.size()), W'(exp_q.size()));
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    #500000;
    chk(1'b0, "watchdog", '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge tx_clk);
    chk({tx_sdo, tx_fsync, tx_bit_vld, rx_overrun} == 4'b0, "R1 during reset",
        W'({tx_sdo, tx_fsync, tx_bit_vld, rx_overrun}), '0);
    do_reset();
    repeat (2) @(negedge tx_clk);
    chk({tx_sdo, tx_fsync, tx_bit_vld, rx_overrun} == 4'b0, "R1 after reset",
        W'({tx_sdo, tx_fsync, tx_bit_vld, rx_overrun}), '0);

    // R2 R9: back-to-back frames at nominal ratio, varied patterns
    begin
      logic [W-1:0] set[6];
      set[0] = '1;
      set[1] = '0;
      set[2] = {32{2'b10}};
      set[3] = {1'b1, {(W-2){1'b0}}, 1'b1};
      set[4] = pat(1);
      set[5] = pat(2);
      for (int k = 0; k < 6; k++) begin
        send_bits(set[k], W);
        exp_q.push_back(set[k]);
      end
    end
    idle_rx(1);
    drain();
    compare("R2 R9 back-to-back");

    // R3: nothing leaves while idle
    repeat (300) @(negedge tx_clk);
    chk(got_q.size() == 0 && !tx_bit_vld, "R3 idle", W'(got_q.size()), '0);

    // R8: bits with no sync are ignored
    for (int i = 0; i < 150; i++) begin
      @(negedge rx_clk);
      rx_sync = 1'b0;
      rx_bit  = i[0] ^ i[2];
    end
    idle_rx(1);
    drain();
    chk(got_q.size() == 0, "R8 unsynced bits", W'(got_q.size()), '0);

    // R7: a partial frame cut short by a new sync is discarded
    send_bits(pat(11), 23);
    send_bits(pat(12), W);
    exp_q.push_back(pat(12));
    idle_rx(1);
    drain();
    compare("R7 resync");

    // R6: receive clock faster than transmit, second frame dropped
    rx_half = 1.5;
    idle_rx(5);
    send_bits(pat(20), W);
    send_bits(pat(21), W);
    exp_q.push_back(pat(20));
    idle_rx(1);
    drain();
    compare("R6 drop keeps first");
    @(negedge rx_clk);
    chk(rx_overrun == 1'b1, "R6 overrun set", W'(rx_overrun), 1);
    send_bits(pat(22), W);
    exp_q.push_back(pat(22));
    idle_rx(1);
    drain();
    compare("R6 later frame passes");
    chk(rx_overrun == 1'b1, "R6 overrun sticky", W'(rx_overrun), 1);
    do_reset();
    @(negedge rx_clk);
    chk(rx_overrun == 1'b0, "R6 cleared by reset", W'(rx_overrun), 0);

    // R10: sweep of clock ratios and phases, gapped frames
    begin
      real halves[5];
      halves[0] = 8.138;
      halves[1] = 2.63;
      halves[2] = 5.07;
      halves[3] = 11.71;
      halves[4] = 3.33;
      for (int h = 0; h < 5; h++) begin
        rx_half = halves[h];
        idle_rx(3);
        for (int k = 0; k < 3; k++) begin
          send_bits(pat(100 + h * 3 + k), W);
          exp_q.push_back(pat(100 + h * 3 + k));
          idle_rx(40);
        end
        drain();
        compare("R10 ratio sweep");
      end
    end
    chk(rx_overrun == 1'b0, "R10 no overrun with spacing", W'(rx_overrun), 0);

    // R4: framing of every output word
    chk(mon_err == 0, "R4 fsync and valid run", W'(mon_err), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule